// File: doc/BRIEF.md
# FPU Control and Status Unit

This unit keeps the control word, the tag word, the sticky status flags and the stack-top pointer of a classic stack-based floating-point unit. It also executes the small auxiliary instruction group that touches only this state: reinitialising the unit, clearing the exception flags and copying the status word to the low 16 bits of the integer accumulator. An instruction arrives as a valid strobe with a 2-bit group selector and a 3-bit sub-encoding field. The sub-encodings that are not defined are reported as illegal.

The status flags are held without the top pointer. The 16-bit status word that software sees is formed by merging the separately held 3-bit top pointer into bits 13:11. The rest of the floating-point datapath updates the state through side inputs: sticky flag events, top-pointer writes, control-word loads and tag-word loads. All instruction responses are registered and appear one cycle after the accepting edge.

Top module: `fpu_ctl_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit loads the initial image: control word 0x037F, tag word 0xFFFF, status flags 0 and top pointer 0. All response pulses (`ax_we`, `illegal`, `ip_hold`) are 0 after reset.
- R2: Group 0 with field 3 (initialise) loads the R1 image at the accepting edge and pulses `ip_hold` in the next cycle. It takes precedence over a flag event, a top write, a control load or a tag load in the same cycle.
- R3: Group 0 with field 2 (clear exceptions) clears status bits 0–7 and bit 15. The layout is invalid=0, denormal=1, zero-divide=2, overflow=3, underflow=4, precision=5, stack fault=6, summary=7, busy=15. It keeps C0=8, C1=9, C2=10, C3=14 and the top pointer, and it pulses `ip_hold`.
- R4: Group 0 with field 0, 1 or 4 changes no state and raises no pulse.
- R5: Group 0 with field 5, 6 or 7 pulses `illegal` for one cycle and changes no state.
- R6: Group 1 with field 0 pulses `ax_we` and `ip_hold` in the next cycle, with `ax_data` equal to the status word as it stood in the accepting cycle.
- R7: Group 1 with field 1–7 pulses `illegal`, does not pulse `ax_we` and changes no state.
- R8: Group 2 with field 0 is a no-op. Group 2 with field 1–7 pulses `illegal`.
- R9: Every field of group 3 pulses `illegal`.
- R10: Status word bits 13:11 always equal the top pointer. Bits 13:11 of a flag event are ignored, and the other event bits are ORed into the sticky flags.
- R11: When a flag event coincides with clear exceptions, the clear is applied first and the event bits survive.
- R12: With `in_valid` low, the group and field inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| in_group | input | 2 | Instruction group: 0 init, 1 store-status, 2 no-op, 3 reserved |
| in_field | input | 3 | Sub-encoding field |
| evt_valid | input | 1 | Sticky flag event strobe |
| evt_flags | input | 16 | Flag bits ORed into the status |
| top_wr | input | 1 | Top pointer write strobe |
| top_val | input | 3 | New top pointer |
| cw_wr | input | 1 | Control word load strobe |
| cw_val | input | 16 | New control word |
| tag_wr | input | 1 | Tag word load strobe |
| tag_val | input | 16 | New tag word |
| ctrl_word | output | 16 | Current control word |
| tag_word | output | 16 | Current tag word |
| status_word | output | 16 | Flags merged with the top pointer |
| ax_data | output | 16 | Value for the accumulator low half |
| ax_we | output | 1 | Accumulator write pulse |
| illegal | output | 1 | Illegal-encoding pulse |
| ip_hold | output | 1 | Suppress the instruction-pointer update |

## Verification
Every one of the 32 group/field pairs is applied after the same preload: all flags set, top = 5, a non-reset control word and a cleared tag word. This shows which state each encoding touches, separating the no-ops, the clear, the initialise, the store and the illegal codes. Directed patterns check the merging of the top pointer, including event bits on top of the top field, as well as a clear that coincides with an event, an initialise that coincides with side writes, a strobe-less instruction and a mid-run reset.

// File: rtl/fcs_pkg.sv
// Package: shared constants and types of the FPU control and status unit.
// Assumes a 16-bit status word with the top pointer at bits 13:11.
package fcs_pkg;
    localparam int WORD_W   = 16;
    localparam int TOP_W    = 3;
    localparam int TOP_LSB  = 11;
    localparam int FIELD_W  = 3;
    localparam int GROUP_W  = 2;
    localparam int TOP_MSB  = TOP_LSB + TOP_W - 1;

    localparam logic [WORD_W-1:0] CW_RESET   = 16'h037F;
    localparam logic [WORD_W-1:0] TAG_RESET  = 16'hFFFF;
    localparam logic [WORD_W-1:0] CLEX_MASK  = 16'h80FF;
    localparam logic [WORD_W-1:0] TOP_MASK   = ((WORD_W)'((1 << TOP_W) - 1)) << TOP_LSB;

    localparam logic [GROUP_W-1:0] GRP_INIT = 2'd0;
    localparam logic [GROUP_W-1:0] GRP_STSW = 2'd1;
    localparam logic [GROUP_W-1:0] GRP_NOP  = 2'd2;

    typedef enum logic [2:0] {
        OPK_NONE = 3'd0,
        OPK_NOP  = 3'd1,
        OPK_CLEX = 3'd2,
        OPK_INIT = 3'd3,
        OPK_STSW = 3'd4,
        OPK_ILL  = 3'd5
    } opk_e;
endpackage

// File: rtl/fcs_decode.sv
// Module: fcs_decode
// Maps a (group, field) pair to one operation kind. Purely combinational.
// Assumes one instruction per valid cycle; invalid cycles give OPK_NONE.
module fcs_decode
    import fcs_pkg::*;
(
    input  logic               valid,
    input  logic [GROUP_W-1:0] grp,
    input  logic [FIELD_W-1:0] fld,
    output opk_e               op
);
    // Decode the group, then the field within it.
    always_comb begin
        op = OPK_NONE;
        if (valid) begin
            if (grp == GRP_INIT) begin
                case (fld)
                    3'd0, 3'd1, 3'd4: op = OPK_NOP;
                    3'd2:             op = OPK_CLEX;
                    3'd3:             op = OPK_INIT;
                    default:          op = OPK_ILL;
                endcase
            end else if (grp == GRP_STSW) begin
                op = (fld == 3'd0) ? OPK_STSW : OPK_ILL;
            end else if (grp == GRP_NOP) begin
                op = (fld == 3'd0) ? OPK_NOP : OPK_ILL;
            end else begin
                op = OPK_ILL;
            end
        end
    end
endmodule

// File: rtl/fcs_state.sv
// Module: fcs_state
// Holds control word, tag word, sticky flags and top pointer.
// Assumes the top field of the flags register is never stored (kept zero).
module fcs_state
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  opk_e              op,
    input  logic              evt_valid,
    input  logic [WORD_W-1:0] evt_flags,
    input  logic              top_wr,
    input  logic [TOP_W-1:0]  top_val,
    input  logic              cw_wr,
    input  logic [WORD_W-1:0] cw_val,
    input  logic              tag_wr,
    input  logic [WORD_W-1:0] tag_val,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] tag_q,
    output logic [WORD_W-1:0] flags_q,
    output logic [TOP_W-1:0]  top_q
);
    logic              do_init;
    logic              do_clr;
    logic [WORD_W-1:0] keep_mask;
    logic [WORD_W-1:0] evt_bits;
    logic [WORD_W-1:0] flags_nx;

    // Classify the operation for the state update.
    always_comb begin
        do_init   = (op == OPK_INIT);
        do_clr    = (op == OPK_CLEX);
        keep_mask = do_clr ? ~CLEX_MASK : '1;
        evt_bits  = evt_valid ? (evt_flags & ~TOP_MASK) : '0;
        flags_nx  = (flags_q & keep_mask) | evt_bits;
    end

    // Register update: reset and initialise share one image.
    always_ff @(posedge clk) begin
        if (!rst_n || do_init) begin
            ctrl_q  <= CW_RESET;
            tag_q   <= TAG_RESET;
            flags_q <= '0;
            top_q   <= '0;
        end else begin
            if (cw_wr)  ctrl_q <= cw_val;
            if (tag_wr) tag_q  <= tag_val;
            if (top_wr) top_q  <= top_val;
            flags_q <= flags_nx;
        end
    end

    assert_init_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (ctrl_q == CW_RESET && tag_q == TAG_RESET && flags_q == '0 && top_q == '0));

    assert_clex_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clr && !evt_valid) |=> ((flags_q & CLEX_MASK) == '0 &&
                                    (flags_q & ~CLEX_MASK) == $past(flags_q & ~CLEX_MASK)));

    assert_no_top_in_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q[TOP_MSB:TOP_LSB] == '0);

    assert_quiet_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_init && !cw_wr) |=> $stable(ctrl_q));

    assert_evt_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_clr && evt_valid) |=> ((flags_q & $past(evt_flags & ~TOP_MASK)) == $past(evt_flags & ~TOP_MASK)));
endmodule

// File: rtl/fcs_merge.sv
// Module: fcs_merge
// Builds the visible status word by inserting the top pointer into its field.
// Assumes the flags input carries zeros in the top field.
module fcs_merge
    import fcs_pkg::*;
(
    input  logic [WORD_W-1:0] flags,
    input  logic [TOP_W-1:0]  top,
    output logic [WORD_W-1:0] status
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i >= TOP_LSB && i <= TOP_MSB) begin : g_top
            // Top field bit: ORed with the (zero) stored flag bit.
            assign status[i] = flags[i] | top[i-TOP_LSB];
        end else begin : g_flag
            // Ordinary flag bit passes straight through.
            assign status[i] = flags[i];
        end
    end
endmodule

// File: rtl/fcs_resp.sv
// Module: fcs_resp
// Registers the per-instruction responses: accumulator write, illegal, hold.
// Assumes the status input reflects state before the accepting edge.
module fcs_resp
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  opk_e              op,
    input  logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] ax_data_q,
    output logic              ax_we_q,
    output logic              ill_q,
    output logic              hold_q
);
    // One-cycle response pulses; accumulator data captured on store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ax_data_q <= '0;
            ax_we_q   <= 1'b0;
            ill_q     <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            ax_we_q <= (op == OPK_STSW);
            ill_q   <= (op == OPK_ILL);
            hold_q  <= (op == OPK_STSW) || (op == OPK_CLEX) || (op == OPK_INIT);
            if (op == OPK_STSW) ax_data_q <= status;
        end
    end

    assert_ill_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ill_q |-> (!ax_we_q && !hold_q));

    assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ax_we_q |-> hold_q);

    assert_store_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPK_STSW) |=> (ax_we_q && ax_data_q == $past(status)));
endmodule

// File: rtl/fpu_ctl_status.sv
// Module: fpu_ctl_status
// Top of the FPU control and status unit: decode, state, merge, response.
// Assumes synchronous active-low reset and at most one instruction per cycle.
module fpu_ctl_status
    import fcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  in_group,
    input  logic [2:0]  in_field,
    input  logic        evt_valid,
    input  logic [15:0] evt_flags,
    input  logic        top_wr,
    input  logic [2:0]  top_val,
    input  logic        cw_wr,
    input  logic [15:0] cw_val,
    input  logic        tag_wr,
    input  logic [15:0] tag_val,
    output logic [15:0] ctrl_word,
    output logic [15:0] tag_word,
    output logic [15:0] status_word,
    output logic [15:0] ax_data,
    output logic        ax_we,
    output logic        illegal,
    output logic        ip_hold
);
    opk_e              op;
    logic [WORD_W-1:0] flags_q;
    logic [TOP_W-1:0]  top_q;

    fcs_decode u_dec (
        .valid (in_valid),
        .grp   (in_group),
        .fld   (in_field),
        .op    (op)
    );

    fcs_state u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .evt_valid (evt_valid),
        .evt_flags (evt_flags),
        .top_wr    (top_wr),
        .top_val   (top_val),
        .cw_wr     (cw_wr),
        .cw_val    (cw_val),
        .tag_wr    (tag_wr),
        .tag_val   (tag_val),
        .ctrl_q    (ctrl_word),
        .tag_q     (tag_word),
        .flags_q   (flags_q),
        .top_q     (top_q)
    );

    fcs_merge u_mrg (
        .flags  (flags_q),
        .top    (top_q),
        .status (status_word)
    );

    fcs_resp u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .status    (status_word),
        .ax_data_q (ax_data),
        .ax_we_q   (ax_we),
        .ill_q     (illegal),
        .hold_q    (ip_hold)
    );

    assert_top_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        top_wr |=> (status_word[13:11] == $past(top_val) || $past(op == OPK_INIT)));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!ax_we && !illegal && !ip_hold));
endmodule

// File: tb/tb_fpu_ctl_status.sv
`timescale 1ns/1ps
module tb_fpu_ctl_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_group = '0;
    logic [2:0]  in_field = '0;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_flags = '0;
    logic        top_wr = 1'b0;
    logic [2:0]  top_val = '0;
    logic        cw_wr = 1'b0;
    logic [15:0] cw_val = '0;
    logic        tag_wr = 1'b0;
    logic [15:0] tag_val = '0;
    logic [15:0] ctrl_word, tag_word, status_word, ax_data;
    logic        ax_we, illegal, ip_hold;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpu_ctl_status dut (.*);

    // Entry: {group, field, class}; class 0 nop, 1 clear, 2 init, 3 store, 4 illegal
    localparam logic [7:0] VEC [32] = '{
        {2'd0,3'd0,3'd0}, {2'd0,3'd1,3'd0}, {2'd0,3'd2,3'd1}, {2'd0,3'd3,3'd2},
        {2'd0,3'd4,3'd0}, {2'd0,3'd5,3'd4}, {2'd0,3'd6,3'd4}, {2'd0,3'd7,3'd4},
        {2'd1,3'd0,3'd3}, {2'd1,3'd1,3'd4}, {2'd1,3'd2,3'd4}, {2'd1,3'd3,3'd4},
        {2'd1,3'd4,3'd4}, {2'd1,3'd5,3'd4}, {2'd1,3'd6,3'd4}, {2'd1,3'd7,3'd4},
        {2'd2,3'd0,3'd0}, {2'd2,3'd1,3'd4}, {2'd2,3'd2,3'd4}, {2'd2,3'd3,3'd4},
        {2'd2,3'd4,3'd4}, {2'd2,3'd5,3'd4}, {2'd2,3'd6,3'd4}, {2'd2,3'd7,3'd4},
        {2'd3,3'd0,3'd4}, {2'd3,3'd1,3'd4}, {2'd3,3'd2,3'd4}, {2'd3,3'd3,3'd4},
        {2'd3,3'd4,3'd4}, {2'd3,3'd5,3'd4}, {2'd3,3'd6,3'd4}, {2'd3,3'd7,3'd4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] g, input logic [2:0] c);
        case (c)
            3'd1: return "R3";
            3'd2: return "R2";
            3'd3: return "R6";
            3'd0: return (g == 2'd0) ? "R4" : "R8";
            default: case (g)
                2'd0: return "R5";
                2'd1: return "R7";
                2'd2: return "R8";
                default: return "R9";
            endcase
        endcase
    endfunction

    // Preload: all flags, top 5, control 0x1234, tag 0 -> status 0xEFFF
    task automatic preload();
        @(negedge clk);
        evt_valid = 1'b1; evt_flags = 16'hFFFF;
        top_wr = 1'b1; top_val = 3'd5;
        cw_wr = 1'b1; cw_val = 16'h1234;
        tag_wr = 1'b1; tag_val = 16'h0000;
        @(negedge clk);
        evt_valid = 1'b0; top_wr = 1'b0; cw_wr = 1'b0; tag_wr = 1'b0;
    endtask

    task automatic issue(input logic [1:0] g, input logic [2:0] f, input bit v);
        @(negedge clk);
        in_valid = v; in_group = g; in_field = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset image
        chk(ctrl_word == 16'h037F, "R1", "ctrl", ctrl_word, 16'h037F);
        chk(tag_word == 16'hFFFF, "R1", "tag", tag_word, 16'hFFFF);
        chk(status_word == 16'h0000, "R1", "status", status_word, 16'h0000);
        chk({ax_we, illegal, ip_hold} == 3'b000, "R1", "pulses",
            {13'd0, ax_we, illegal, ip_hold}, 16'h0);

        // Table walk over every encoding
        for (int k = 0; k < 32; k++) begin
            logic [1:0] g; logic [2:0] f, c;
            logic [15:0] es, ec, et;
            string r;
            {g, f, c} = VEC[k];
            r = req_of(g, c);
            preload();
            chk(status_word == 16'hEFFF, "R10", "preload status", status_word, 16'hEFFF);
            issue(g, f, 1'b1);
            es = (c == 3'd2) ? 16'h0000 : (c == 3'd1) ? 16'h6F00 : 16'hEFFF;
            ec = (c == 3'd2) ? 16'h037F : 16'h1234;
            et = (c == 3'd2) ? 16'hFFFF : 16'h0000;
            chk(status_word == es, r, "status", status_word, es);
            chk(ctrl_word == ec, r, "ctrl", ctrl_word, ec);
            chk(tag_word == et, r, "tag", tag_word, et);
            chk(illegal == (c == 3'd4), r, "illegal", {15'd0, illegal}, {15'd0, c == 3'd4});
            chk(ax_we == (c == 3'd3), r, "ax_we", {15'd0, ax_we}, {15'd0, c == 3'd3});
            chk(ip_hold == (c == 3'd1 || c == 3'd2 || c == 3'd3), r, "ip_hold",
                {15'd0, ip_hold}, {15'd0, c == 3'd1 || c == 3'd2 || c == 3'd3});
            if (c == 3'd3)
                chk(ax_data == 16'hEFFF, r, "ax_data", ax_data, 16'hEFFF);
            @(negedge clk);
            chk({ax_we, illegal, ip_hold} == 3'b000, r, "pulse width",
                {13'd0, ax_we, illegal, ip_hold}, 16'h0);
        end

        // R12: no strobe, clear encoding on the field lines
        preload();
        issue(2'd0, 3'd2, 1'b0);
        chk(status_word == 16'hEFFF, "R12", "status", status_word, 16'hEFFF);
        chk(ip_hold == 1'b0, "R12", "ip_hold", {15'd0, ip_hold}, 16'h0);

        // R11: clear coinciding with an event on invalid bit
        @(negedge clk);
        in_valid = 1'b1; in_group = 2'd0; in_field = 3'd2;
        evt_valid = 1'b1; evt_flags = 16'h0001;
        @(negedge clk);
        in_valid = 1'b0; evt_valid = 1'b0;
        chk(status_word == 16'h6F01, "R11", "clear+event", status_word, 16'h6F01);

        // R2: initialise coinciding with side writes
        @(negedge clk);
        in_valid = 1'b1; in_group = 2'd0; in_field = 3'd3;
        evt_valid = 1'b1; evt_flags = 16'h0010; top_wr = 1'b1; top_val = 3'd3;
        cw_wr = 1'b1; cw_val = 16'hAAAA; tag_wr = 1'b1; tag_val = 16'h5555;
        @(negedge clk);
        in_valid = 1'b0; evt_valid = 1'b0; top_wr = 1'b0; cw_wr = 1'b0; tag_wr = 1'b0;
        chk(status_word == 16'h0000, "R2", "init precedence status", status_word, 16'h0000);
        chk(ctrl_word == 16'h037F, "R2", "init precedence ctrl", ctrl_word, 16'h037F);
        chk(tag_word == 16'hFFFF, "R2", "init precedence tag", tag_word, 16'hFFFF);

        // R10: event bits on the top field are dropped; top 6 shows at 13:11
        @(negedge clk);
        evt_valid = 1'b1; evt_flags = 16'h3800; top_wr = 1'b1; top_val = 3'd6;
        @(negedge clk);
        evt_valid = 1'b0; top_wr = 1'b0;
        chk(status_word == 16'h3000, "R10", "top merge", status_word, 16'h3000);
        issue(2'd1, 3'd0, 1'b1);
        chk(ax_data == 16'h3000, "R10", "stored status", ax_data, 16'h3000);
        chk(ax_we == 1'b1, "R6", "ax_we", {15'd0, ax_we}, 16'h1);

        // R1: reset in mid run
        preload();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(status_word == 16'h0000, "R1", "mid-run status", status_word, 16'h0000);
        chk(ctrl_word == 16'h037F, "R1", "mid-run ctrl", ctrl_word, 16'h037F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule